// File: doc/BRIEF.md
# Serial Presence Table Slave

This block is a two-wire serial bus slave that exposes a 256-byte configuration table to a bus master. It takes the raw clock line and data line as inputs and passes both through two-flop synchronizers. It finds edges and bus conditions in the local sampling clock domain, which must run at least eight times faster than the bus clock. It drives the data line only through a pull-low enable, so the line stays open-drain. Its device address is a fixed type code joined to three strap inputs, so up to eight such tables can share one bus.

A controller built around one state machine moves through these states. IDLE is standby. ADDR shifts in the address byte. ADDR_ACK drives the acknowledge for a matching address. WORD takes the pointer byte and WORD_ACK acknowledges it. WDATA takes a data byte and DATA_ACK acknowledges it. RDATA shifts a table byte out. MACK samples the master's acknowledge. PARK waits silently.

The transitions are as follows. A start moves any state to ADDR, and a stop moves any state to IDLE. From ADDR, a matching address goes to ADDR_ACK and any other address goes to PARK. ADDR_ACK goes to RDATA for a read or to WORD for a write. WORD goes to WORD_ACK, and WORD_ACK goes to WDATA. WDATA goes to DATA_ACK, which returns to WDATA. RDATA goes to MACK after eight bits. MACK returns to RDATA when the master acknowledges and goes to PARK when it does not.

Top module: `spd_slave`

## Requirements
- R1: After reset, standby_o is 1 and sda_pull_o is 0, and standby_o is never 1 while sda_pull_o is 1.
- R2: Bus activity that is not preceded by a start condition (data line falling while the clock line is high) is ignored: no acknowledge is driven and standby_o stays 1. A start drops standby_o.
- R3: An address byte (MSB first) whose bits 7:4 are 1010 and bits 3:1 equal strap_i is acknowledged by pulling the data line low during the ninth clock pulse. Bit 0 of the byte selects read (1) or write (0).
- R4: An address byte that does not match gets no acknowledge. The slave then drives nothing until the next start or stop, and standby_o stays 0 until a stop.
- R5: In a write transfer, the first byte after the address loads the 8-bit table pointer and is acknowledged.
- R6: Each later write byte is acknowledged and stored at the pointer. The pointer then increments and wraps from 255 to 0.
- R7: In a read transfer, the slave sends the byte at the pointer MSB first and then increments the pointer, wrapping at 255. A read that follows a new start without a pointer write continues from the pointer left by the previous transfer.
- R8: After a read byte that the master acknowledges, the next byte follows. After a byte that the master does not acknowledge, the slave releases the data line for all further pulses until a start or stop.
- R9: A stop condition (data line rising while the clock line is high) returns the slave to standby (standby_o = 1) from any state.
- R10: A repeated start with no stop in between is accepted and restarts address matching. This allows a pointer write followed by a read.
- R11: sda_pull_o changes only while the clock line is low.
- R12: After reset, table byte i holds i XOR 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Address strap bits, address bits 3:1 |
| sda_pull_o | output | 1 | When 1, the pad pulls the data line low |
| standby_o | output | 1 | 1 while the slave is in standby |

## Verification
On every cycle the assertions check the following: the pull enable moves only while the synchronized clock line is low; standby never overlaps a pull; a stop always lands in standby; a start always leaves it; the parked state never drives the line; and a table write lands at the addressed cell. Address matching, pointer wrap, table contents and the continue-or-halt decision after the master's acknowledge can be shown only by the bench. The bench does this with bus scenarios: mismatched codes and straps, repeated starts, current-pointer reads, reads past a refused acknowledge, and random bursts compared against a table model.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_DATA_ACK,
        ST_RDATA,
        ST_MACK,
        ST_PARK
    } spd_state_e;

endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/spd_mem.sv
module spd_mem #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] INIT_KEY = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= DATA_W'(i) ^ INIT_KEY;
            end
        end else if (wr_en) begin
            cells[addr] <= wr_data;
        end
    end

    assign rd_data = cells[addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[$past(addr)] == $past(wr_data))
        else $error("table write did not land"); // R6

endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
    import spd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sda_pull_o,
    output logic              standby_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    spd_state_e        state;
    spd_state_e        nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [ADDR_W-1:0] ptr;
    logic              rw;
    logic              mack_ok;
    logic              load_ptr;
    logic              load_tx;

    // next-state decision
    always_comb begin
        nxt = state;
        if (stop_evt) begin
            nxt = ST_IDLE;
        end else if (start_evt) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_PARK: nxt = state;
                ST_ADDR: begin
                    if (scl_fall && byte_done)
                        nxt = (rx_sr[BYTE_W-1:1] == dev_addr) ? ST_ADDR_ACK : ST_PARK;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) nxt = rw ? ST_RDATA : ST_WORD;
                end
                ST_WORD: begin
                    if (scl_fall && byte_done) nxt = ST_WORD_ACK;
                end
                ST_WORD_ACK: begin
                    if (scl_fall) nxt = ST_WDATA;
                end
                ST_WDATA: begin
                    if (scl_fall && byte_done) nxt = ST_DATA_ACK;
                end
                ST_DATA_ACK: begin
                    if (scl_fall) nxt = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall && bit_cnt == LAST_BIT) nxt = ST_MACK;
                end
                ST_MACK: begin
                    if (scl_fall) nxt = mack_ok ? ST_RDATA : ST_PARK;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign load_ptr  = (state == ST_WORD) && (nxt == ST_WORD_ACK);
    assign mem_we    = (state == ST_WDATA) && (nxt == ST_DATA_ACK);
    assign load_tx   = (nxt == ST_RDATA) && (state != ST_RDATA);
    assign mem_addr  = ptr;
    assign mem_wdata = rx_sr;

    // shift registers, bit counter and table pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            rx_sr     <= '0;
            tx_sr     <= '1;
            ptr       <= '0;
            rw        <= 1'b0;
            mack_ok   <= 1'b0;
        end else begin
            if (start_evt || stop_evt) begin
                bit_cnt   <= '0;
                byte_done <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WORD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sr     <= {rx_sr[BYTE_W-2:0], sda_s};
                            bit_cnt   <= bit_cnt + CNT_W'(1);
                            byte_done <= (bit_cnt == LAST_BIT);
                        end else if (scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            bit_cnt   <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack_ok <= ~sda_s;
                    end
                    default: ;
                endcase
            end
            if (state == ST_ADDR && nxt == ST_ADDR_ACK) rw <= rx_sr[0];
            if (load_ptr) ptr <= rx_sr[ADDR_W-1:0];
            if (mem_we)   ptr <= ptr + ADDR_W'(1);
            if (load_tx) begin
                tx_sr   <= mem_rdata;
                ptr     <= ptr + ADDR_W'(1);
                bit_cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = 1'b0;
        standby_o  = 1'b0;
        unique case (state)
            ST_IDLE:                             standby_o  = 1'b1;
            ST_ADDR_ACK, ST_WORD_ACK, ST_DATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                            sda_pull_o = ~tx_sr[BYTE_W-1];
            default: ;
        endcase
    end

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s)
        else $error("pull changed with clock line high"); // R11

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !sda_pull_o)
        else $error("pull while in standby"); // R1

    AST_STOP_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> standby_o)
        else $error("stop did not reach standby"); // R9

    AST_START_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (!standby_o && !sda_pull_o))
        else $error("start did not leave standby"); // R2

    AST_PARK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK) |-> !sda_pull_o)
        else $error("parked slave drives the line"); // R8

endmodule

// File: rtl/spd_slave.sv
module spd_slave #(
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] TYPE_CODE   = 4'b1010,
    parameter logic [7:0] INIT_KEY    = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_pull_o,
    output logic       standby_o
);

    localparam int BYTE_W = spd_pkg::BYTE_W;

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] mem_rdata;
    logic [6:0]        dev_addr;

    assign dev_addr = {TYPE_CODE, strap_i};

    spd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    spd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .dev_addr   (dev_addr),
        .mem_rdata  (mem_rdata),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .sda_pull_o (sda_pull_o),
        .standby_o  (standby_o)
    );

    spd_mem #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (BYTE_W),
        .INIT_KEY (INIT_KEY)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .addr    (mem_addr),
        .wr_data (mem_wdata),
        .rd_data (mem_rdata)
    );

endmodule

// File: tb/tb_spd_slave.sv
module tb_spd_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    wire        sda_bus;
    logic       sda_pull;
    logic       standby;

    localparam logic [7:0] WADDR = {4'b1010, 3'b101, 1'b0};
    localparam logic [7:0] RADDR = {4'b1010, 3'b101, 1'b1};

    assign sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    spd_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .standby_o  (standby)
    );

    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;
    int         r11_bad = 0;
    logic       scl_prev = 1'b1;
    logic       pull_prev = 1'b0;
    logic [7:0] model [256];
    logic [7:0] bptr = 8'h00;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic m, output logic s);
        tick(5); sda_m = m;
        tick(5); scl_m = 1'b1;
        tick(5); s = sda_bus;
        tick(5); scl_m = 1'b0;
    endtask

    task automatic do_start();
        tick(5); sda_m = 1'b1;
        tick(5); scl_m = 1'b1;
        tick(5); sda_m = 1'b0;
        tick(5); scl_m = 1'b0;
    endtask

    task automatic do_stop();
        tick(5); sda_m = 1'b0;
        tick(5); scl_m = 1'b1;
        tick(5); sda_m = 1'b1;
        tick(5);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic s;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b1, s);
            b = {b[6:0], s};
        end
        bit_cycle(give_ack ? 1'b0 : 1'b1, s);
    endtask

    task automatic wr_burst(input logic [7:0] p, input int n);
        bit a;
        logic [7:0] d;
        do_start();
        send_byte(WADDR, a);  chk("R3 write address ack", int'(a), 1);
        send_byte(p, a);      chk("R5 pointer byte ack", int'(a), 1);
        bptr = p;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, a);  chk("R6 data byte ack", int'(a), 1);
            model[bptr] = d;
            bptr = bptr + 8'd1;
        end
        do_stop();
    endtask

    task automatic rd_burst(input logic [7:0] p, input int n, input string req);
        bit a;
        logic [7:0] d;
        do_start();
        send_byte(WADDR, a);  chk("R3 write address ack", int'(a), 1);
        send_byte(p, a);      chk("R5 pointer byte ack", int'(a), 1);
        do_start();
        send_byte(RADDR, a);  chk("R10 read address after repeated start", int'(a), 1);
        bptr = p;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(req, int'(d), int'(model[bptr]));
            bptr = bptr + 8'd1;
        end
        do_stop();
    endtask

    // R11 monitor: pull enable must hold while the clock line stays high
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (pull_prev !== sda_pull)) r11_bad++;
        scl_prev  = scl_m;
        pull_prev = sda_pull;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit         a;
        logic [7:0] d;
        logic [7:0] rp;
        int         rn;
        int         seed_v;
        seed_v = $urandom(32'd77);
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;

        tick(4);
        rst_n = 1'b1;
        tick(4);
        chk("R1 standby after reset", int'(standby), 1);
        chk("R1 no pull after reset", int'(sda_pull), 0);

        // R2: clocking without a start is ignored
        scl_m = 1'b0;
        send_byte(WADDR, a);
        chk("R2 no ack without start", int'(a), 0);
        chk("R2 standby kept without start", int'(standby), 1);
        tick(5); scl_m = 1'b1; tick(5);

        // R2 / R3 / R5 / R6 / R9: directed write
        do_start();
        tick(2);
        chk("R2 start leaves standby", int'(standby), 0);
        send_byte(WADDR, a);  chk("R3 matching address ack", int'(a), 1);
        send_byte(8'h10, a);  chk("R5 pointer ack", int'(a), 1);
        bptr = 8'h10;
        for (int k = 0; k < 3; k++) begin
            d = 8'hC0 + 8'(k);
            send_byte(d, a);  chk("R6 data ack", int'(a), 1);
            model[bptr] = d;
            bptr = bptr + 8'd1;
        end
        do_stop();
        chk("R9 stop returns to standby", int'(standby), 1);

        // R7 / R10: pointer write, repeated start, sequential read
        rd_burst(8'h10, 3, "R7 sequential read data");

        // R12: reset contents
        rd_burst(8'h80, 2, "R12 reset table content");

        // R7: current-pointer read continues where the last read stopped
        do_start();
        send_byte(RADDR, a);  chk("R3 read address ack", int'(a), 1);
        recv_byte(1'b0, d);
        chk("R7 current pointer read", int'(d), int'(model[bptr]));
        bptr = bptr + 8'd1;
        do_stop();

        // R8: refused acknowledge halts data
        do_start();
        send_byte(WADDR, a);
        send_byte(8'h20, a);
        do_start();
        send_byte(RADDR, a);
        recv_byte(1'b1, d);   chk("R8 first byte", int'(d), int'(model[8'h20]));
        recv_byte(1'b0, d);   chk("R8 second byte", int'(d), int'(model[8'h21]));
        recv_byte(1'b0, d);   chk("R8 line released after refused ack", int'(d), 8'hFF);
        chk("R8 no standby before stop", int'(standby), 0);
        do_stop();
        chk("R9 standby after parked stop", int'(standby), 1);
        bptr = 8'h22;

        // R6 / R7: pointer wrap
        do_start();
        send_byte(WADDR, a);
        send_byte(8'hFE, a);
        bptr = 8'hFE;
        for (int k = 0; k < 3; k++) begin
            d = 8'h31 + 8'(k);
            send_byte(d, a);  chk("R6 ack across wrap", int'(a), 1);
            model[bptr] = d;
            bptr = bptr + 8'd1;
        end
        do_stop();
        rd_burst(8'hFE, 3, "R7 read across wrap");
        rd_burst(8'h00, 1, "R6 write wrapped to cell 0");

        // R4: mismatched strap and mismatched type code
        do_start();
        send_byte({4'b1010, 3'b100, 1'b0}, a);
        chk("R4 wrong strap not acked", int'(a), 0);
        send_byte(8'h00, a);
        chk("R4 later byte not acked", int'(a), 0);
        chk("R4 no standby before stop", int'(standby), 0);
        do_stop();
        chk("R9 standby after mismatch stop", int'(standby), 1);
        do_start();
        send_byte({4'b1011, 3'b101, 1'b1}, a);
        chk("R4 wrong type code not acked", int'(a), 0);
        recv_byte(1'b0, d);
        chk("R4 no data after mismatch", int'(d), 8'hFF);
        do_stop();

        // random bursts against the model
        for (int it = 0; it < 20; it++) begin
            rp = 8'($urandom);
            rn = 1 + int'($urandom % 4);
            wr_burst(rp, rn);
            rd_burst(rp, rn, "R7 random read back");
        end

        chk("R11 pull stable while clock high", r11_bad, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule